// File: doc/BRIEF.md
# Split-Access 64-bit Register Bank

This block holds the two 64-bit settings words that a downstream address translation unit reads: a control word and a table base word. Both words drive the outputs at all times. A third slot is reserved for a flush command that has no side effect here. Software reaches the words over a simple strobe bus. Each access is either 64 bits or 32 bits wide, and 32-bit accesses choose one half of a word by address.

The halves sit big-endian: a 32-bit access at a word's own offset touches bits 63:32, and an access four bytes above it touches bits 31:0. A partial write merges with the half it does not touch. A 32-bit read returns its half right-aligned on the read bus, with zeros above it. Reads answer one cycle after the strobe, with a single-cycle valid pulse. Reset clears both words, so the translation unit starts out disabled.

Top module: `split_reg_bank`

## Requirements
- R1: While `rst` is high and after it falls, `ctrl_q`, `base_q`, `rdata` and `rvalid` are all zero until the first access.
- R2: A write with `size64`=1 at offset 0x00 (control) or 0x08 (base) replaces all 64 bits of that word with `wdata`, and the new value is on the output the cycle after the strobe.
- R3: A write with `size64`=0 at offset 0x00 or 0x08 puts `wdata[31:0]` into bits 63:32 of the word and leaves bits 31:0 unchanged.
- R4: A write at offset 0x04 or 0x0C puts `wdata[31:0]` into bits 31:0 of the word and leaves bits 63:32 unchanged, whatever `size64` is.
- R5: A read with `size64`=1 at 0x00 or 0x08 returns the whole word. A read with `size64`=0 at those offsets returns bits 63:32 in `rdata[31:0]`. A read at 0x04 or 0x0C of either size returns bits 31:0 in `rdata[31:0]`. A 32-bit result always has `rdata[63:32]` zero.
- R6: `rvalid` is high for exactly the one cycle after each cycle with `rd_en` high and is low otherwise. `rdata` is meaningful only while `rvalid` is high.
- R7: Writes to the flush offsets 0x10 and 0x14 change neither word, and reads from them return zero.
- R8: Accesses to any other offset, including offsets whose two low bits are not zero, change neither word, and reads from them return zero.
- R9: A read and a write in the same cycle to the same word return the value the word held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (8) | Byte offset of the access |
| size64 | input | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| wdata | input | 64 | Write data; a 32-bit write uses bits 31:0 |
| rdata | output | 64 | Read data, valid while `rvalid` is high |
| rvalid | output | 1 | One-cycle read response pulse |
| ctrl_q | output | 64 | Current control word |
| base_q | output | 64 | Current table base word |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any check counts. They also assume that the inputs are stable around the rising edge, and that `addr`, `size64` and `wdata` are defined in every cycle in which a strobe is high. The bench changes every input on the falling edge only and resets the block before it issues any access. In idle cycles it drives defined values on every input. The random phase draws offsets from the decoded set plus a few illegal ones. This keeps reads and writes to every half and every width inside the assumed protocol, and it includes cycles where a read and a write hit the same word.

// File: rtl/srb_pkg.sv
package srb_pkg;

    localparam int REG_W         = 64;
    localparam int HALF_W        = REG_W / 2;
    localparam int BYTES_PER_REG = REG_W / 8;
    localparam int STRIDE_SH     = $clog2(BYTES_PER_REG);
    localparam int HALF_SH       = STRIDE_SH - 1;
    localparam int BANK_REGS     = 2;
    localparam int IDX_W         = 8;

    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_REG   = 2'd1,
        TGT_FLUSH = 2'd2
    } tgt_e;

    typedef enum logic {
        PART_HI = 1'b0,
        PART_LO = 1'b1
    } part_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] idx;
        part_e            part;
        logic             wide;
    } access_t;

    // New word value after a write described by acc.
    function automatic reg_t merge_word(reg_t old_w, reg_t wd, access_t acc);
        reg_t res;
        if (acc.part == PART_LO) begin
            res = {old_w[REG_W-1:HALF_W], wd[HALF_W-1:0]};
        end else if (acc.wide) begin
            res = wd;
        end else begin
            res = {wd[HALF_W-1:0], old_w[HALF_W-1:0]};
        end
        return res;
    endfunction

    // Value placed on the read bus for a read described by acc.
    function automatic reg_t select_word(reg_t cur, access_t acc);
        reg_t res;
        if (acc.part == PART_LO) begin
            res = {{HALF_W{1'b0}}, cur[HALF_W-1:0]};
        end else if (acc.wide) begin
            res = cur;
        end else begin
            res = {{HALF_W{1'b0}}, cur[REG_W-1:HALF_W]};
        end
        return res;
    endfunction

endpackage

// File: rtl/srb_decode.sv
module srb_decode
    import srb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              size64,
    output access_t           acc
);
    localparam int WORD_BITS = ADDR_W - STRIDE_SH;

    logic [WORD_BITS-1:0] word_no;
    logic                 aligned;

    assign word_no = addr[ADDR_W-1:STRIDE_SH];
    assign aligned = (addr[HALF_SH-1:0] == '0);

    always_comb begin
        acc.tgt  = TGT_NONE;
        acc.idx  = IDX_W'(word_no);
        acc.part = addr[HALF_SH] ? PART_LO : PART_HI;
        acc.wide = size64;
        if (aligned) begin
            if (word_no < WORD_BITS'(NUM_WORDS)) begin
                acc.tgt = TGT_REG;
            end else if (word_no == WORD_BITS'(NUM_WORDS)) begin
                acc.tgt = TGT_FLUSH;
            end
        end
    end
endmodule

// File: rtl/srb_word.sv
module srb_word
    import srb_pkg::*;
#(
    parameter int WORD_IDX = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  access_t acc,
    input  reg_t    wdata,
    output reg_t    q
);
    logic hit;

    assign hit = wr_en && (acc.tgt == TGT_REG) && (acc.idx == IDX_W'(WORD_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (hit) begin
            q <= merge_word(q, wdata, acc);
        end
    end
endmodule

// File: rtl/srb_rdmux.sv
module srb_rdmux
    import srb_pkg::*;
#(
    parameter int NUM_WORDS = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_en,
    input  access_t acc,
    input  reg_t    words [NUM_WORDS],
    output reg_t    rdata,
    output logic    rvalid
);
    reg_t picked;

    always_comb begin
        picked = '0;
        if (acc.tgt == TGT_REG) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (acc.idx == IDX_W'(i)) begin
                    picked = select_word(words[i], acc);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) begin
                rdata <= picked;
            end
        end
    end
endmodule

// File: rtl/split_reg_bank.sv
module split_reg_bank
    import srb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              size64,
    input  logic [63:0]       wdata,
    output logic [63:0]       rdata,
    output logic              rvalid,
    output logic [63:0]       ctrl_q,
    output logic [63:0]       base_q
);
    access_t acc;
    reg_t    words [BANK_REGS];

    srb_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(BANK_REGS)
    ) u_decode (
        .addr  (addr),
        .size64(size64),
        .acc   (acc)
    );

    for (genvar g = 0; g < BANK_REGS; g++) begin : g_word
        srb_word #(
            .WORD_IDX(g)
        ) u_word (
            .clk  (clk),
            .rst  (rst),
            .wr_en(wr_en),
            .acc  (acc),
            .wdata(wdata),
            .q    (words[g])
        );
    end

    srb_rdmux #(
        .NUM_WORDS(BANK_REGS)
    ) u_rdmux (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .acc   (acc),
        .words (words),
        .rdata (rdata),
        .rvalid(rvalid)
    );

    assign ctrl_q = words[0];
    assign base_q = words[1];
endmodule

// File: rtl/srb_checker.sv
module srb_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              size64,
    input logic [63:0]       wdata,
    input logic [63:0]       rdata,
    input logic              rvalid,
    input logic [63:0]       ctrl_q,
    input logic [63:0]       base_q
);
    localparam logic [ADDR_W-1:0] A_CTRL_HI = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] A_CTRL_LO = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] A_FLUSH_0 = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] A_FLUSH_1 = ADDR_W'(8'h14);

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid); // R6
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rvalid); // R6
    AST_IDLE_WORDS_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(ctrl_q) && $stable(base_q))); // R8
    AST_FULL_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && size64 && addr == A_CTRL_HI) |=> (ctrl_q == $past(wdata))); // R2
    AST_UPPER_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !size64 && addr == A_CTRL_HI) |=> (ctrl_q[31:0] == $past(ctrl_q[31:0]))); // R3
    AST_LOWER_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTRL_LO) |=> (ctrl_q[63:32] == $past(ctrl_q[63:32]))); // R4
    AST_NARROW_READ_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !size64) |=> (rdata[63:32] == 32'h0)); // R5
    AST_FLUSH_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == A_FLUSH_0 || addr == A_FLUSH_1)) |=> (rdata == 64'h0)); // R7
    AST_FLUSH_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == A_FLUSH_0 || addr == A_FLUSH_1)) |=> ($stable(ctrl_q) && $stable(base_q))); // R7
endmodule

bind split_reg_bank srb_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_split_reg_bank.sv
module sim_split_reg_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = 8'h0;
    logic        size64 = 1'b0;
    logic [63:0] wdata = 64'h0;
    logic [63:0] rdata;
    logic        rvalid;
    logic [63:0] ctrl_q;
    logic [63:0] base_q;

    int tests = 0;
    int fails = 0;
    logic [63:0] m_ctrl = 64'h0;
    logic [63:0] m_base = 64'h0;

    split_reg_bank #(.ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .size64(size64), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .ctrl_q(ctrl_q), .base_q(base_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model_read(input logic [7:0] a, input logic sz);
        case (a)
            8'h00: return sz ? m_ctrl : {32'h0, m_ctrl[63:32]};
            8'h04: return {32'h0, m_ctrl[31:0]};
            8'h08: return sz ? m_base : {32'h0, m_base[63:32]};
            8'h0C: return {32'h0, m_base[31:0]};
            default: return 64'h0;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic sz, input logic [63:0] d);
        case (a)
            8'h00: m_ctrl = sz ? d : {d[31:0], m_ctrl[31:0]};
            8'h04: m_ctrl = {m_ctrl[63:32], d[31:0]};
            8'h08: m_base = sz ? d : {d[31:0], m_base[31:0]};
            8'h0C: m_base = {m_base[63:32], d[31:0]};
            default: ;
        endcase
    endtask

    // One bus cycle: drive at falling edge, compare just after the rising edge.
    task automatic step(input string req, input logic wr, input logic rd,
                        input logic [7:0] a, input logic sz, input logic [63:0] d);
        logic [63:0] exp_rd;
        @(negedge clk);
        wr_en = wr; rd_en = rd; addr = a; size64 = sz; wdata = d;
        exp_rd = model_read(a, sz);
        if (wr) model_write(a, sz, d);
        @(posedge clk);
        #1;
        chk(req, "ctrl_q", ctrl_q, m_ctrl);
        chk(req, "base_q", base_q, m_base);
        chk(req, "rvalid", {63'h0, rvalid}, {63'h0, rd});
        if (rd) chk(req, "rdata", rdata, exp_rd);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        m_ctrl = 64'h0; m_base = 64'h0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "ctrl_q in reset", ctrl_q, 64'h0);
        chk("R1", "base_q in reset", base_q, 64'h0);
        chk("R1", "rvalid in reset", {63'h0, rvalid}, 64'h0);
        chk("R1", "rdata in reset", rdata, 64'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        step("R1", 0, 1, 8'h00, 1, 64'h0);
        step("R2", 1, 0, 8'h00, 1, 64'h1122_3344_5566_7788);
        step("R2", 1, 0, 8'h08, 1, 64'hA5A5_0000_FFFF_1234);
        step("R5", 0, 1, 8'h00, 1, 64'h0);
        step("R5", 0, 1, 8'h00, 0, 64'h0);
        step("R5", 0, 1, 8'h04, 0, 64'h0);
        step("R5", 0, 1, 8'h04, 1, 64'h0);
        step("R5", 0, 1, 8'h0C, 0, 64'h0);
        step("R3", 1, 0, 8'h00, 0, 64'hFFFF_FFFF_DEAD_BEEF);
        step("R3", 1, 0, 8'h08, 0, 64'h0000_0000_CAFE_F00D);
        step("R4", 1, 0, 8'h04, 0, 64'h9999_9999_0BAD_C0DE);
        step("R4", 1, 0, 8'h0C, 1, 64'h7777_7777_1357_9BDF);
        step("R6", 0, 0, 8'h00, 1, 64'h0);
        step("R6", 0, 1, 8'h08, 1, 64'h0);
        step("R6", 0, 1, 8'h08, 0, 64'h0);
        step("R6", 0, 0, 8'h08, 0, 64'h0);
        step("R7", 1, 0, 8'h10, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R7", 1, 0, 8'h14, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R7", 0, 1, 8'h10, 1, 64'h0);
        step("R7", 0, 1, 8'h14, 0, 64'h0);
        step("R8", 1, 0, 8'h18, 1, 64'h1);
        step("R8", 1, 0, 8'h02, 1, 64'h2);
        step("R8", 1, 0, 8'h0E, 0, 64'h3);
        step("R8", 1, 0, 8'hF0, 1, 64'h4);
        step("R8", 0, 1, 8'h01, 1, 64'h0);
        step("R8", 0, 1, 8'hFC, 0, 64'h0);
        step("R9", 1, 1, 8'h00, 1, 64'h0F0F_0F0F_F0F0_F0F0);
        step("R9", 1, 1, 8'h0C, 0, 64'h0000_0000_1111_2222);
        step("R9", 0, 1, 8'h00, 1, 64'h0);
        do_reset();
        step("R1", 0, 1, 8'h08, 1, 64'h0);
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            int pick = $urandom_range(0, 9);
            case (pick)
                0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
                4: a = 8'h10; 5: a = 8'h14; 6: a = 8'h18;
                7: a = 8'h06; 8: a = 8'h00; default: a = 8'h08;
            endcase
            step("R5", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
                 1'($urandom_range(0, 1)), {$urandom(), $urandom()});
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule